// File: doc/BRIEF.md
# Time-Shared Synchronisation-Sequence Correlator

This block is a matched filter for a slow complex baseband stream running on a much faster system clock. Each accepted sample is shifted into a 128-deep delay line. The delay line is correlated against one fixed 128-tap complex sequence, and the block returns an unsigned estimate of the magnitude of the correlation. The input arrives at only a small fraction of the clock rate, so each complex multiplier serves a whole group of taps one after another inside a single sample period. `MULT_REUSE` sets how many taps share one multiplier, and the number of complex multiply lanes is `TAPS / MULT_REUSE`.

Each complex product is formed from three real multiplications. The magnitude is approximated with shifts, compares and adds only. Which of the three sequence variants an instance detects is fixed at elaboration by `SEQ_ID`. A receiver that searches for all three variants places three instances side by side. The output feeds a downstream peak picker.

Top module: `shared_mac_corr`

## Requirements
- R1: A sample is packed with signed I in the upper half of `inSample` and signed Q in the lower half, each `IN_DW/2` bits wide. A high `inValid` is taken when no accumulation window is running.
- R2: Tap k has real part `A*d(k mod 127)` and imaginary part `A*d((k+63) mod 127)`. Here `A = 2^(TAP_DW/2-2)` and `d(n) = 1 - 2*x((n + 43*SEQ_ID) mod 127)`. The bits come from `x(i+7) = x(i+4) xor x(i)`, starting from x(0..6) = 0,1,1,0,1,1,1.
- R3: For the newest sample x[n], the complex sum is `y = sum over k of x[n-k]*c[k]`, with no conjugation. It is exact for every input, full-scale negative values included.
- R4: The magnitude equals `max(|Re y|,|Im y|) + floor(min(|Re y|,|Im y|)/2)`, held on G = IN_DW/2 + TAP_DW/2 + 1 + log2(128) bits (40 for the defaults).
- R5: When `OUT_DW >= G`, `outMag` is the magnitude zero-extended. When `OUT_DW < G`, `outMag` holds the upper `OUT_DW` bits of the G-bit magnitude.
- R6: For every result, `outValid` is a pulse one cycle long. It appears exactly `MULT_REUSE+3` clock edges after the edge that took the sample.
- R7: After reset, the first 127 accepted samples produce no output. Every accepted sample from the 128th on produces exactly one output.
- R8: An `inValid` that is high while a window is running (the `MULT_REUSE` cycles after an accepting edge) is ignored and never enters the delay line. Accepted samples must be at least `MULT_REUSE+1` edges apart.
- R9: While `rstN` is low, `outValid` is low, and the count of samples toward the first output restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Qualifies `inSample` |
| inSample | input | IN_DW | Complex sample, I upper half, Q lower half |
| outValid | output | 1 | Qualifies `outMag` |
| outMag | output | OUT_DW | Approximate correlation magnitude |

## Verification
A fault in the tap counter or the lane selection sends the wrong sample–tap pairs into the sum. This corrupts the magnitude of the very first result after priming, MULT_REUSE+3 cycles after the 128th sample. A fault in the window or fill logic shows up as a missing, extra or late `outValid` pulse, which the bench counts against each accepted sample. A stray sample let in during a busy window shifts the delay line, and every magnitude after that no longer matches the bench's history model.

// File: rtl/shared_mac_corr_pkg.sv
package shared_mac_corr_pkg;

  typedef struct packed {
    logic shiftIn;   // take a new sample into the delay line
    logic macEn;     // a tap product is issued this cycle
    logic macFirst;  // first tap of the window
    logic macLast;   // last tap of the window
    logic emit;      // this window yields an output
  } ctrlStrobe_t;

  // Bit i of the length-127 binary sequence.
  function automatic logic seqBit(input int n);
    logic [6:0] win;
    win = 7'b1110110;
    for (int i = 0; i < n; i++) begin
      win = {win[4] ^ win[0], win[6:1]};
    end
    return win[0];
  endfunction

  // Sign of one tap component: part 0 is real, part 1 is imaginary.
  function automatic int tapSign(input int seqId, input int k, input int part);
    int idx;
    idx = (part == 0) ? (k % 127) : ((k + 63) % 127);
    idx = (idx + 43 * seqId) % 127;
    return seqBit(idx) ? -1 : 1;
  endfunction

endpackage

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import shared_mac_corr_pkg::*;
#(
  parameter int TAPS       = 128,
  parameter int MULT_REUSE = 64,
  parameter int IDXW       = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  output ctrlStrobe_t     strobe,
  output logic [IDXW-1:0] tapIdx
);

  localparam int FW = $clog2(TAPS + 1);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(MULT_REUSE - 1);
  localparam logic [FW-1:0]   PRIME_AT = FW'(TAPS - 1);
  localparam logic [FW-1:0]   FILL_MAX = FW'(TAPS);

  logic            busy;
  logic            jobEmit;
  logic [IDXW-1:0] idxQ;
  logic [FW-1:0]   fillCnt;

  always_comb begin
    strobe.shiftIn  = inValid && !busy;
    strobe.macEn    = busy;
    strobe.macFirst = busy && (idxQ == '0);
    strobe.macLast  = busy && (idxQ == LAST_IDX);
    strobe.emit     = jobEmit;
  end

  assign tapIdx = idxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      jobEmit <= 1'b0;
      idxQ    <= '0;
      fillCnt <= '0;
    end else if (strobe.shiftIn) begin
      busy    <= 1'b1;
      idxQ    <= '0;
      jobEmit <= (fillCnt >= PRIME_AT);
      if (fillCnt != FILL_MAX) fillCnt <= fillCnt + 1'b1;
    end else if (busy) begin
      idxQ <= idxQ + 1'b1;
      if (idxQ == LAST_IDX) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/smc_mag.sv
module smc_mag #(
  parameter int W      = 40,
  parameter int OUT_DW = 48
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic signed [W-1:0] re,
  input  logic signed [W-1:0] im,
  output logic                outValid,
  output logic [OUT_DW-1:0]   outMag
);

  localparam int SHIFT = (W > OUT_DW) ? (W - OUT_DW) : 0;

  logic [W-1:0] absRe, absIm, bigPart, smallPart, magFull;

  always_comb begin
    absRe     = re[W-1] ? W'(-re) : W'(re);
    absIm     = im[W-1] ? W'(-im) : W'(im);
    bigPart   = (absRe >= absIm) ? absRe : absIm;
    smallPart = (absRe >= absIm) ? absIm : absRe;
    magFull   = bigPart + (smallPart >> 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outMag   <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) outMag <= OUT_DW'(magFull >> SHIFT);
    end
  end

endmodule

// File: rtl/smc_datapath.sv
module smc_datapath
  import shared_mac_corr_pkg::*;
#(
  parameter int IN_DW      = 32,
  parameter int TAP_DW     = 32,
  parameter int OUT_DW     = 48,
  parameter int TAPS       = 128,
  parameter int MULT_REUSE = 64,
  parameter int SEQ_ID     = 0,
  parameter int IDXW       = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [IDXW-1:0]   tapIdx,
  input  logic [IN_DW-1:0]  inSample,
  output logic              outValid,
  output logic [OUT_DW-1:0] outMag
);

  localparam int IW    = IN_DW / 2;
  localparam int TW    = TAP_DW / 2;
  localparam int PW    = IW + TW + 1;
  localparam int ACCW  = PW + $clog2(TAPS);
  localparam int LANES = TAPS / MULT_REUSE;
  localparam logic signed [TW-1:0] AMP_P = TW'(1) << (TW - 2);
  localparam logic signed [TW-1:0] AMP_N = -AMP_P;

  logic [IN_DW-1:0]       dl [TAPS];
  logic signed [TW-1:0]   coefRe [TAPS];
  logic signed [TW-1:0]   coefIm [TAPS];
  logic signed [PW-1:0]   prodRe [LANES];
  logic signed [PW-1:0]   prodIm [LANES];
  logic signed [ACCW-1:0] accRe  [LANES];
  logic signed [ACCW-1:0] accIm  [LANES];
  logic                   pValid, pFirst, pLast, pEmit, accDone, sumValid;
  logic signed [ACCW-1:0] sumReD, sumImD, sumReQ, sumImQ;

  // Constant tap table.
  for (genvar k = 0; k < TAPS; k++) begin : g_coef
    assign coefRe[k] = (tapSign(SEQ_ID, k, 0) > 0) ? AMP_P : AMP_N;
    assign coefIm[k] = (tapSign(SEQ_ID, k, 1) > 0) ? AMP_P : AMP_N;
  end

  // Sample history, newest at index 0.
  always_ff @(posedge clk) begin
    if (strobe.shiftIn) begin
      dl[0] <= inSample;
      for (int k = 1; k < TAPS; k++) dl[k] <= dl[k-1];
    end
  end

  // Flags that travel alongside the product registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pValid  <= 1'b0;
      pFirst  <= 1'b0;
      pLast   <= 1'b0;
      pEmit   <= 1'b0;
      accDone <= 1'b0;
    end else begin
      pValid  <= strobe.macEn;
      pFirst  <= strobe.macFirst;
      pLast   <= strobe.macLast;
      pEmit   <= strobe.emit;
      accDone <= pValid && pLast && pEmit;
    end
  end

  for (genvar m = 0; m < LANES; m++) begin : g_lane
    logic signed [IW-1:0] xr, xi;
    logic signed [TW-1:0] cr, ci;
    logic signed [IW:0]   xSum;
    logic signed [TW:0]   cSum, cDif;
    logic signed [PW:0]   k1, k2, k3, re, im;

    always_comb begin
      int sel;
      sel  = m * MULT_REUSE + int'(tapIdx);
      xr   = dl[sel][IN_DW-1:IW];
      xi   = dl[sel][IW-1:0];
      cr   = coefRe[sel];
      ci   = coefIm[sel];
      xSum = (IW+1)'(xr) + (IW+1)'(xi);
      cSum = (TW+1)'(cr) + (TW+1)'(ci);
      cDif = (TW+1)'(ci) - (TW+1)'(cr);
      k1   = (PW+1)'(cr) * (PW+1)'(xSum);
      k2   = (PW+1)'(xr) * (PW+1)'(cDif);
      k3   = (PW+1)'(xi) * (PW+1)'(cSum);
      re   = k1 - k3;
      im   = k1 + k2;
    end

    always_ff @(posedge clk) begin
      if (strobe.macEn) begin
        prodRe[m] <= PW'(re);
        prodIm[m] <= PW'(im);
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accRe[m] <= '0;
        accIm[m] <= '0;
      end else if (pValid) begin
        accRe[m] <= (pFirst ? '0 : accRe[m]) + ACCW'(prodRe[m]);
        accIm[m] <= (pFirst ? '0 : accIm[m]) + ACCW'(prodIm[m]);
      end
    end
  end

  always_comb begin
    sumReD = '0;
    sumImD = '0;
    for (int m = 0; m < LANES; m++) begin
      sumReD = sumReD + accRe[m];
      sumImD = sumImD + accIm[m];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumValid <= 1'b0;
      sumReQ   <= '0;
      sumImQ   <= '0;
    end else begin
      sumValid <= accDone;
      if (accDone) begin
        sumReQ <= sumReD;
        sumImQ <= sumImD;
      end
    end
  end

  smc_mag #(.W(ACCW), .OUT_DW(OUT_DW)) u_mag (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (sumValid),
    .re       (sumReQ),
    .im       (sumImQ),
    .outValid (outValid),
    .outMag   (outMag)
  );

endmodule

// File: rtl/shared_mac_corr.sv
module shared_mac_corr
  import shared_mac_corr_pkg::*;
#(
  parameter int IN_DW      = 32,
  parameter int TAP_DW     = 32,
  parameter int OUT_DW     = 48,
  parameter int TAPS       = 128,
  parameter int MULT_REUSE = 64,
  parameter int SEQ_ID     = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [IN_DW-1:0]  inSample,
  output logic              outValid,
  output logic [OUT_DW-1:0] outMag
);

  localparam int IDXW = (MULT_REUSE > 1) ? $clog2(MULT_REUSE) : 1;

  ctrlStrobe_t     strobe;
  logic [IDXW-1:0] tapIdx;

  smc_ctrl #(.TAPS(TAPS), .MULT_REUSE(MULT_REUSE), .IDXW(IDXW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .tapIdx  (tapIdx)
  );

  smc_datapath #(
    .IN_DW(IN_DW), .TAP_DW(TAP_DW), .OUT_DW(OUT_DW), .TAPS(TAPS),
    .MULT_REUSE(MULT_REUSE), .SEQ_ID(SEQ_ID), .IDXW(IDXW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tapIdx   (tapIdx),
    .inSample (inSample),
    .outValid (outValid),
    .outMag   (outMag)
  );

endmodule

// File: rtl/smc_checker.sv
module smc_checker
  import shared_mac_corr_pkg::*;
#(
  parameter int TAPS = 128
) (
  input logic        clk,
  input logic        rstN,
  input logic        outValid,
  input ctrlStrobe_t strobe
);

  int acceptCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acceptCnt <= 0;
    else if (strobe.shiftIn && acceptCnt < TAPS) acceptCnt <= acceptCnt + 1;
  end

  // R8: a window starts right after an acceptance
  p_window_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftIn |=> (strobe.macEn && strobe.macFirst));

  // R8: no acceptance while a window runs
  p_no_shift_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.macEn |-> !strobe.shiftIn);

  // R8: the last tap closes the window
  p_window_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.macLast |=> !strobe.macEn);

  // R6: single-cycle output pulse
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R6: fixed distance from the last tap to the output
  p_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.macLast && strobe.emit) |-> ##4 outValid);

  p_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strobe.macLast && strobe.emit, 4));

  // R7: no output before the delay line has been filled
  p_primed_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (acceptCnt >= TAPS));

endmodule

bind shared_mac_corr smc_checker #(.TAPS(TAPS)) u_smc_checker (
  .clk      (clk),
  .rstN     (rstN),
  .outValid (outValid),
  .strobe   (strobe)
);

// File: tb/test_shared_mac_corr.sv
module test_shared_mac_corr;

  localparam int IN_DW  = 32;
  localparam int TAP_DW = 32;
  localparam int OUT_DW = 48;
  localparam int NARROW = 24;
  localparam int TAPS   = 128;
  localparam int REUSE  = 64;
  localparam int SEQ    = 1;
  localparam int GROW   = IN_DW/2 + TAP_DW/2 + 1 + $clog2(TAPS);
  localparam int NSAMP  = 172;
  localparam longint AMP = longint'(1) << (TAP_DW/2 - 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [IN_DW-1:0] inSample = '0;
  logic outValid, outValidN;
  logic [OUT_DW-1:0] outMag;
  logic [NARROW-1:0] outMagN;

  always #2 clk = ~clk;

  shared_mac_corr #(.IN_DW(IN_DW), .TAP_DW(TAP_DW), .OUT_DW(OUT_DW),
    .TAPS(TAPS), .MULT_REUSE(REUSE), .SEQ_ID(SEQ)) i_shared_mac_corr (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .outValid(outValid), .outMag(outMag));

  shared_mac_corr #(.IN_DW(IN_DW), .TAP_DW(TAP_DW), .OUT_DW(NARROW),
    .TAPS(TAPS), .MULT_REUSE(REUSE), .SEQ_ID(SEQ)) i_shared_mac_corr_narrow (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .outValid(outValidN), .outMag(outMagN));

  int total = 0;
  int bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit     seqB [127];
  longint cR [TAPS];
  longint cI [TAPS];
  longint hI [TAPS];
  longint hQ [TAPS];
  longint expMag [NSAMP];
  longint accCyc [NSAMP];
  int nAcc = 0;
  int nOut = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2: tap table from the requirement
  task automatic buildTaps();
    bit x [127];
    x[0]=0; x[1]=1; x[2]=1; x[3]=0; x[4]=1; x[5]=1; x[6]=1;
    for (int i = 0; i + 7 < 127; i++) x[i+7] = x[i+4] ^ x[i];
    for (int i = 0; i < 127; i++) seqB[i] = x[i];
    for (int k = 0; k < TAPS; k++) begin
      cR[k] = seqB[((k % 127) + 43*SEQ) % 127] ? -AMP : AMP;
      cI[k] = seqB[(((k + 63) % 127) + 43*SEQ) % 127] ? -AMP : AMP;
    end
  endtask

  // R3, R4: expected magnitude from the history
  function automatic longint model();
    longint re = 0, im = 0, a, b;
    for (int k = 0; k < TAPS; k++) begin
      re += hI[k]*cR[k] - hQ[k]*cI[k];
      im += hI[k]*cI[k] + hQ[k]*cR[k];
    end
    a = (re < 0) ? -re : re;
    b = (im < 0) ? -im : im;
    return (a >= b) ? a + (b >>> 1) : b + (a >>> 1);
  endfunction

  task automatic sendSample(input int si, input int sq, input int gap, input int spurPos);
    @(negedge clk);
    inValid  = 1'b1;
    inSample = {si[15:0], sq[15:0]};
    for (int k = TAPS-1; k > 0; k--) begin hI[k] = hI[k-1]; hQ[k] = hQ[k-1]; end
    hI[0] = longint'(si);
    hQ[0] = longint'(sq);
    accCyc[nAcc] = cyc + 1;
    expMag[nAcc] = model();
    nAcc++;
    for (int g = 1; g < gap; g++) begin
      @(negedge clk);
      inValid = (g == spurPos);  // R8: stray pulse inside the window
      if (g == spurPos) inSample = $urandom;
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Output monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      int s;
      s = nOut + TAPS - 1;
      if (s >= nAcc) begin
        check(1'b0, "R7 output before priming", s, nAcc);
      end else begin
        check(outMag == OUT_DW'(expMag[s]), "R3/R4 magnitude", longint'(outMag), expMag[s]);
        check(outValidN == 1'b1, "R5 narrow valid", longint'(outValidN), 1);
        check(outMagN == NARROW'(expMag[s] >>> (GROW - NARROW)), "R5 truncated magnitude",
              longint'(outMagN), expMag[s] >>> (GROW - NARROW));
        check(cyc == accCyc[s] + REUSE + 3, "R6 latency", cyc - accCyc[s], REUSE + 3);
      end
      nOut++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    buildTaps();
    for (int k = 0; k < TAPS; k++) begin hI[k] = 0; hQ[k] = 0; end
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R9 reset outValid", longint'(outValid), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R9 outValid after reset", longint'(outValid), 0);
    for (int n = 0; n < NSAMP; n++) begin
      int si, sq, gap, spur;
      if (n >= 140 && n < 156) begin
        si = -32768; sq = -32768;      // R3: full-scale stretch
      end else if (n >= 156 && n < 162) begin
        si = 0; sq = 0;
      end else if (n % 29 == 5) begin
        si = 32767; sq = -32768;
      end else begin
        si = int'($urandom_range(65535)) - 32768;
        sq = int'($urandom_range(65535)) - 32768;
      end
      gap  = (n % 3 == 0) ? REUSE : REUSE + int'($urandom_range(15));  // R8: minimum spacing too
      spur = (n % 4 == 1) ? 1 + int'($urandom_range(REUSE - 2)) : 0;
      sendSample(si, sq, gap, spur);
    end
    repeat (REUSE + 10) @(negedge clk);
    check(nOut == nAcc - (TAPS - 1), "R7 output count", nOut, nAcc - (TAPS - 1));
    check(nAcc == NSAMP, "R1 accepted count", nAcc, NSAMP);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule